// File: doc/BRIEF.md
# Three-Stage Cascadable Down-Counter with Toggle Output

This block holds three 8-bit down-counters. Each counter has a reload latch and its own count-source select. Counter A counts either a slow sub-clock enable or a fast enable, which is the main clock divided by 16. Counters B and C each count either the underflows of counter A or the fast enable. Counter A can therefore act as a prescaler for the other two. On every underflow of counter B, a level output can invert. The output starts from a selectable level. A control register, written over a simple CPU port, sets all of these options. The same port reads the running counter values.

The block also gates the CPU clock when the processor leaves its stopped state. A stop request freezes all counting and drops the CPU clock enable. A later wake request reloads counters A and B from their latches. The CPU clock enable then stays low until counter B underflows, which gives a programmable settling delay. Reset enters the same settling wait, with counter A preset to 255 and counter B preset to 1. While the CPU clock enable is low, writes from the CPU port are ignored.

Register addresses: 0 is the control register, 1 is counter A, 2 is counter B, 3 is counter C. Control register bits:
- bit 0: start level (0 starts high, 1 starts low)
- bit 1: output enable
- bit 2: counter B write mode
- bit 3: counter B source
- bit 4: counter C source
- bit 5: counter A source

Top module: `cascade_timer`

## Requirements
- R1: After reset, the control register reads 0, counter A reads 255, counter B reads 1 and `cpu_clk_en` is 0. With `sub_ce` held high, `cpu_clk_en` rises after exactly 512 clock edges.
- R2: A counter decrements on each enabled tick. When it is 0 at a tick, it reloads from its latch instead, and its `irqN` output is high for that cycle only. With latch value L, the counter therefore underflows once every L+1 ticks.
- R3: Control bit 5 selects counter A's source: 0 counts `sub_ce`, 1 counts `div_ce`. Ticks on the unselected input have no effect.
- R4: Control bit 3 selects counter B's source and control bit 4 selects counter C's source. For each, 0 counts counter A underflows and 1 counts `div_ce`. When cascaded, counter B underflows once every (A+1)×(B+1) ticks of counter A's source.
- R5: When control bit 2 is 0, a write to counter B loads both its latch and its counter. When bit 2 is 1, the write loads the latch only, and the new value first appears in the counter at the next reload.
- R6: A write to counter A or counter C loads both the latch and the counter. A read of address 1, 2 or 3 returns the counter's current value.
- R7: Bits 7 and 6 of the control register ignore writes and always read 0.
- R8: `tout_en` equals control bit 1. Every control write sets `tout` to the inverse of bit 0 (bit 0 = 0 gives high, bit 0 = 1 gives low). While bit 1 is 1, `tout` inverts on each underflow of counter B.
- R9: A `stop_req` pulse while running drops `cpu_clk_en` and freezes all counters. A `wake_req` pulse then reloads counters A and B from their latches. `cpu_clk_en` rises on the edge after counter B's next underflow.
- R10: Writes presented while `cpu_clk_en` is 0 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| sub_ce | input | 1 | Slow sub-clock tick enable |
| div_ce | input | 1 | Main-clock/16 tick enable |
| stop_req | input | 1 | Enter stopped state |
| wake_req | input | 1 | Leave stopped state |
| tout | output | 1 | Toggle output level |
| tout_en | output | 1 | Toggle output enable |
| irq1 | output | 1 | Counter A underflow strobe |
| irq2 | output | 1 | Counter B underflow strobe |
| irq3 | output | 1 | Counter C underflow strobe |
| cpu_clk_en | output | 1 | CPU clock enable |

## Verification
The bench measures cascade periods by counting underflow strobes over a known number of ticks. An off-by-one reload would give periods of L instead of L+1, and the counts would not match. It writes counter B in latch-only mode and reads the counter before and after a reload. A design that loaded the counter as well would return the new value too early. It also checks that the toggle output restarts at the chosen level on a control write, that counting is frozen while stopped, that the wake delay is exactly (A+1)×(B+1) ticks from the reloaded latches, and that writes made while the clock is held are dropped.

// File: rtl/cascade_timer.sv
module cascade_timer #(
  parameter int W = 8,
  parameter logic [W-1:0] A_INIT = '1,
  parameter logic [W-1:0] B_INIT = 1,
  parameter logic [W-1:0] C_INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         sub_ce,
  input  logic         div_ce,
  input  logic         stop_req,
  input  logic         wake_req,
  output logic         tout,
  output logic         tout_en,
  output logic         irq1,
  output logic         irq2,
  output logic         irq3,
  output logic         cpu_clk_en
);
  typedef enum logic [1:0] {RUN = 2'd0, HALT = 2'd1, SETTLE = 2'd2} state_t;

  state_t state;
  logic [5:0]   mode;
  logic [W-1:0] cnt1, cnt2, cnt3, lat1, lat2, lat3;
  logic         tq;

  wire counting = (state != HALT);
  wire wake_go  = (state == HALT) && wake_req;
  wire wr_ok    = bus_wr && cpu_clk_en;
  wire wr_mode  = wr_ok && (bus_addr == 2'd0);
  wire wr_a     = wr_ok && (bus_addr == 2'd1);
  wire wr_b     = wr_ok && (bus_addr == 2'd2);
  wire wr_c     = wr_ok && (bus_addr == 2'd3);

  wire tick1 = counting && (mode[5] ? div_ce : sub_ce);
  assign irq1 = tick1 && (cnt1 == '0);
  wire tick2 = counting && (mode[3] ? div_ce : irq1);
  assign irq2 = tick2 && (cnt2 == '0);
  wire tick3 = counting && (mode[4] ? div_ce : irq1);
  assign irq3 = tick3 && (cnt3 == '0);

  assign cpu_clk_en = (state == RUN);
  assign tout       = tq;
  assign tout_en    = mode[1];

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {{(W-6){1'b0}}, mode};
      2'd1:    bus_rdata = cnt1;
      2'd2:    bus_rdata = cnt2;
      default: bus_rdata = cnt3;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SETTLE;
    else case (state)
      RUN:     if (stop_req) state <= HALT;
      HALT:    if (wake_req) state <= SETTLE;
      default: if (irq2) state <= RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
      tq   <= 1'b1;
    end else if (wr_mode) begin
      mode <= bus_wdata[5:0];
      tq   <= ~bus_wdata[0];
    end else if (irq2 && mode[1]) begin
      tq   <= ~tq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat1 <= A_INIT; cnt1 <= A_INIT;
    end else if (wake_go) cnt1 <= lat1;
    else if (wr_a) begin
      lat1 <= bus_wdata; cnt1 <= bus_wdata;
    end else if (tick1) cnt1 <= irq1 ? lat1 : cnt1 - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat2 <= B_INIT; cnt2 <= B_INIT;
    end else begin
      if (wr_b) lat2 <= bus_wdata;
      if (wake_go) cnt2 <= lat2;
      else if (wr_b && !mode[2]) cnt2 <= bus_wdata;
      else if (tick2) cnt2 <= irq2 ? lat2 : cnt2 - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat3 <= C_INIT; cnt3 <= C_INIT;
    end else if (wr_c) begin
      lat3 <= bus_wdata; cnt3 <= bus_wdata;
    end else if (tick3) cnt3 <= irq3 ? lat3 : cnt3 - 1'b1;
  end
endmodule

module cascade_timer_chk #(parameter int W = 8) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic [1:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic         wake_req,
  input logic         irq1,
  input logic         irq2,
  input logic         tout,
  input logic         tout_en,
  input logic         cpu_clk_en,
  input logic [5:0]   mode,
  input logic [W-1:0] cnt1,
  input logic [W-1:0] cnt2,
  input logic [W-1:0] lat1,
  input logic [1:0]   st
);
  wire wr_ok = bus_wr && cpu_clk_en;

  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq1 && !(wr_ok && bus_addr == 2'd1)) |=> cnt1 == $past(lat1));

  assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[W-1:6] == '0));

  assert_load_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && bus_addr == 2'd2 && !mode[2]) |=> cnt2 == $past(bus_wdata));

  assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq2 && tout_en && !(wr_ok && bus_addr == 2'd0)) |=> tout != $past(tout));

  assert_settle_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> $past(irq2));

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && !wake_req) |=> $stable(cnt1) && $stable(cnt2));

  assert_wr_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !cpu_clk_en && bus_addr == 2'd1) |=> $stable(lat1));
endmodule

bind cascade_timer cascade_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_req(wake_req),
  .irq1(irq1), .irq2(irq2), .tout(tout), .tout_en(tout_en),
  .cpu_clk_en(cpu_clk_en), .mode(mode), .cnt1(cnt1), .cnt2(cnt2),
  .lat1(lat1), .st(state)
);

// File: tb/cascade_timer_bench.sv
module cascade_timer_bench;
  logic clk = 0, rst_n = 0, bus_wr = 0, sub_ce = 0, div_ce = 0;
  logic stop_req = 0, wake_req = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic tout, tout_en, irq1, irq2, irq3, cpu_clk_en;
  int checks = 0, fails = 0, n1, n2, n3;
  bit done = 0;

  always #5 clk = ~clk;

  cascade_timer u_cascade_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sub_ce(sub_ce),
    .div_ce(div_ce), .stop_req(stop_req), .wake_req(wake_req),
    .tout(tout), .tout_en(tout_en), .irq1(irq1), .irq2(irq2),
    .irq3(irq3), .cpu_clk_en(cpu_clk_en)
  );

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic tick_fast(int n);
    n1 = 0; n2 = 0; n3 = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); div_ce = 1; #2;
      n1 += irq1; n2 += irq2; n3 += irq3;
    end
    @(negedge clk); div_ce = 0;
  endtask

  task automatic t_reset();
    int v, n;
    rd(0, v); check("R1 mode", v, 0);
    rd(1, v); check("R1 cntA", v, 255);
    rd(2, v); check("R1 cntB", v, 1);
    check("R1 clk held", cpu_clk_en, 0);
    wr(3, 8'd5);
    rd(3, v); check("R10 write ignored", v, 255);
    @(negedge clk); sub_ce = 1; n = 0;
    while (!cpu_clk_en && n < 2000) begin @(negedge clk); n++; end
    sub_ce = 0;
    check("R1 settle edges", n, 512);
    rd(3, v); check("R4 cntC cascade", v, 253);
  endtask

  task automatic t_period();
    int v;
    wr(0, 8'h20); wr(1, 8'd3);
    tick_fast(20);
    check("R2 underflows", n1, 5);
    rd(1, v); check("R2 reload value", v, 3);
  endtask

  task automatic t_cascade();
    wr(0, 8'h20); wr(1, 8'd2); wr(2, 8'd3); wr(3, 8'd1);
    tick_fast(24);
    check("R2 A count", n1, 8);
    check("R4 B cascade", n2, 2);
    check("R4 C cascade", n3, 4);
  endtask

  task automatic t_source();
    int v;
    wr(0, 8'h00); wr(1, 8'd7);
    tick_fast(10);
    check("R3 unselected", n1, 0);
    rd(1, v); check("R3 A unchanged", v, 7);
    wr(0, 8'h18); wr(2, 8'd4); wr(3, 8'd9);
    tick_fast(10);
    check("R4 B fast", n2, 2);
    check("R4 C fast", n3, 1);
    rd(3, v); check("R6 C read", v, 9);
  endtask

  task automatic t_latch_only();
    int v;
    wr(0, 8'h18); wr(2, 8'd5);
    wr(0, 8'h1C); wr(2, 8'd9);
    rd(2, v); check("R5 latch only", v, 5);
    tick_fast(6);
    check("R5 one underflow", n2, 1);
    rd(2, v); check("R5 reload new", v, 9);
  endtask

  task automatic t_toggle();
    int v;
    wr(0, 8'hFA);
    rd(0, v); check("R7 reserved", v, 8'h3A);
    wr(0, 8'h18); wr(2, 8'd1); wr(0, 8'h1A);
    check("R8 start high", tout, 1);
    check("R8 enable", tout_en, 1);
    tick_fast(1); check("R8 no toggle", tout, 1);
    tick_fast(1); check("R8 toggle1", tout, 0);
    tick_fast(2); check("R8 toggle2", tout, 1);
    wr(0, 8'h1B); check("R8 start low", tout, 0);
    tick_fast(2); check("R8 toggle3", tout, 1);
    wr(0, 8'h18); check("R8 disabled", tout_en, 0);
  endtask

  task automatic t_stop();
    int v, n;
    wr(0, 8'h20); wr(1, 8'd1); wr(2, 8'd2);
    tick_fast(1);
    rd(1, v); check("R2 A decrement", v, 0);
    @(negedge clk); stop_req = 1; @(negedge clk); stop_req = 0;
    check("R9 clk dropped", cpu_clk_en, 0);
    tick_fast(10);
    rd(1, v); check("R9 A frozen", v, 0);
    rd(2, v); check("R9 B frozen", v, 2);
    @(negedge clk); wake_req = 1; @(negedge clk); wake_req = 0;
    rd(1, v); check("R9 A reloaded", v, 1);
    n = 0;
    while (!cpu_clk_en && n < 100) begin
      @(negedge clk); div_ce = 1; @(negedge clk); div_ce = 0; n++;
    end
    check("R9 wake delay", n, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_period();
    t_cascade();
    t_source();
    t_latch_only();
    t_toggle();
    t_stop();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule